// File: doc/BRIEF.md
# Translation Context Register Bank with Fault Capture

This block is the register file of one address-translation context in an I/O memory-management unit. Software reaches it over a plain 32-bit register bus. Through that bus it programs the context controls, the translation-table configuration and base, two memory-attribute words and the walk-bus selection. The translation engine sits beside the block and uses a separate port for two things: it reports faults, each with a flag set, an error code, a level and the faulting address, and it acknowledges TLB flushes. The page walk itself is not part of this block.

The context window is 0x40 bytes wide and also appears at a second alias window. Fault status is cleared by writing zero to it, not by writing ones. The error address is taken from the first fault of a burst and stays fixed until software clears the status. A flush request stays set until the engine confirms the flush. One level interrupt is driven while interrupts are enabled and any error flag is set.

Top module: `mmu_ctx_regs`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `flush_req` and `xlat_en` are low.
- R2: Mapped word offsets are 0x00 (control), 0x08 (table config), 0x0C (bus control), 0x10/0x14 (table base low/high), 0x20 (status), 0x28/0x2C (attributes) and 0x30 (error address). Address bit 11 (the 0x800 alias) is ignored, so an access through the alias behaves exactly like an access to the base window. Any other offset, or any offset that is not word aligned, reads zero and ignores writes.
- R3: Control bits 0 (translation enable, drives `xlat_en`), 2 (interrupt enable), 3, 5:4, 16 and 17 are read/write, and all other control bits read zero. Bus control keeps bits 2:0. Table config, both table base words and both attribute words keep all 32 bits.
- R4: Writing 1 to control bit 1 sets the flush request. The bit reads 1 and drives `flush_req` until the engine acknowledges it. Writing 0 to the bit does not clear it.
- R5: `flush_done` clears the flush bit at the next clock edge. If the same cycle also writes 1 to the bit, the bit stays set. An acknowledge that arrives with no flush pending has no effect.
- R6: A status write clears every error flag whose written bit is 0. When no flag remains set, the error code, the error level and the error address all read zero.
- R7: Status layout: bit 0 is a translation fault, bit 1 a page fault, bit 2 a walk abort, bit 4 a multiple hit, bits 10:8 the error code and bits 13:12 the error level. The `flt_flags` bits [0..3] map onto status bits 0, 1, 2 and 4. The error address register is read-only.
- R8: A fault that arrives while every flag is clear latches its address, code and level. Later faults only OR in their flags and leave the latched values unchanged. A fault with no flag bits set is ignored.
- R9: A fault and a status write in the same cycle are merged: the write is applied first and the fault after it. If the write leaves no flag set, that fault counts as the first fault.
- R10: `irq` is high exactly when interrupt enable is set and at least one error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | DW | Write data |
| req_rdata | output | DW | Read data for the current read, combinational, zero otherwise |
| flt_valid | input | 1 | Engine reports a fault |
| flt_flags | input | 4 | Fault kinds: translation, page, walk abort, multiple hit |
| flt_code | input | 3 | Error code of the fault |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | DW | Faulting address |
| flush_done | input | 1 | Engine finished the pending flush |
| flush_req | output | 1 | Flush pending towards the engine |
| xlat_en | output | 1 | Translation enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the engine inputs and the bus inputs are steady around each rising edge. They also assume a status write whose flag bits are all zero really is a clear request. The bench changes every input only at the falling edge, so each input is held for a full half period before it is sampled. The random stimulus mixes status writes that clear some flags with faults, flush acknowledges and accesses through the alias window. Directed cases pin down the same-cycle orderings of R5 and R9.

// File: rtl/mmu_ctx_regs.sv
module mmu_ctx_regs #(
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int WIN_BYTES = 'h40,
  parameter int ALIAS_OFS = 'h800
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_rdata,
  input  logic          flt_valid,
  input  logic [3:0]    flt_flags,
  input  logic [2:0]    flt_code,
  input  logic [1:0]    flt_level,
  input  logic [DW-1:0] flt_addr,
  input  logic          flush_done,
  output logic          flush_req,
  output logic          xlat_en,
  output logic          irq
);
  localparam logic [AW-1:0] ALIAS_MASK = AW'(ALIAS_OFS);
  localparam logic [AW-1:0] OF_CTRL = AW'('h00);
  localparam logic [AW-1:0] OF_TCFG = AW'('h08);
  localparam logic [AW-1:0] OF_BUS  = AW'('h0C);
  localparam logic [AW-1:0] OF_TBL  = AW'('h10);
  localparam logic [AW-1:0] OF_TBH  = AW'('h14);
  localparam logic [AW-1:0] OF_STAT = AW'('h20);
  localparam logic [AW-1:0] OF_AT0  = AW'('h28);
  localparam logic [AW-1:0] OF_AT1  = AW'('h2C);
  localparam logic [AW-1:0] OF_EADR = AW'('h30);
  localparam logic [DW-1:0] CTRL_RW = DW'('h0003_003D);

  logic [AW-1:0] loc;
  logic          mapped, wr;
  logic [DW-1:0] ctrl_q, tcfg_q, tbl_q, tbh_q, at0_q, at1_q, eaddr_q;
  logic [2:0]    bus_q, code_q;
  logic [1:0]    lvl_q;
  logic [3:0]    flags_q, flags_base;
  logic          flush_q, we_stat, first_flt;

  assign loc    = req_addr & ~ALIAS_MASK;
  assign mapped = (loc < AW'(WIN_BYTES)) && (loc[1:0] == 2'b00);
  assign wr     = req_valid && req_write && mapped;
  assign we_stat = wr && (loc == OF_STAT);

  assign flags_base = we_stat ? (flags_q & {req_wdata[4], req_wdata[2:0]}) : flags_q;
  assign first_flt  = flt_valid && (|flt_flags) && (flags_base == 4'b0);

  assign flush_req = flush_q;
  assign xlat_en   = ctrl_q[0];
  assign irq       = ctrl_q[2] && (|flags_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; tcfg_q <= '0; bus_q <= '0; tbl_q <= '0; tbh_q <= '0;
      at0_q  <= '0; at1_q  <= '0; flush_q <= 1'b0;
    end else begin
      if (wr && loc == OF_CTRL) ctrl_q <= req_wdata & CTRL_RW;
      if (wr && loc == OF_TCFG) tcfg_q <= req_wdata;
      if (wr && loc == OF_BUS)  bus_q  <= req_wdata[2:0];
      if (wr && loc == OF_TBL)  tbl_q  <= req_wdata;
      if (wr && loc == OF_TBH)  tbh_q  <= req_wdata;
      if (wr && loc == OF_AT0)  at0_q  <= req_wdata;
      if (wr && loc == OF_AT1)  at1_q  <= req_wdata;
      flush_q <= (wr && loc == OF_CTRL && req_wdata[1]) || (flush_q && !flush_done);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0; code_q <= '0; lvl_q <= '0; eaddr_q <= '0;
    end else begin
      flags_q <= flags_base | (flt_valid ? flt_flags : 4'b0);
      if (first_flt) begin
        code_q <= flt_code; lvl_q <= flt_level; eaddr_q <= flt_addr;
      end else if (flags_base == 4'b0) begin
        code_q <= '0; lvl_q <= '0; eaddr_q <= '0;
      end
    end
  end

  always_comb begin
    req_rdata = '0;
    if (req_valid && !req_write && mapped) begin
      case (loc)
        OF_CTRL: req_rdata = ctrl_q | (DW'(flush_q) << 1);
        OF_TCFG: req_rdata = tcfg_q;
        OF_BUS:  req_rdata = DW'(bus_q);
        OF_TBL:  req_rdata = tbl_q;
        OF_TBH:  req_rdata = tbh_q;
        OF_STAT: req_rdata = DW'({lvl_q, 1'b0, code_q, 3'b000, flags_q[3], 1'b0, flags_q[2:0]});
        OF_AT0:  req_rdata = at0_q;
        OF_AT1:  req_rdata = at1_q;
        OF_EADR: req_rdata = (|flags_q) ? eaddr_q : '0;
        default: req_rdata = '0;
      endcase
    end
  end

  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && !flush_done |=> flush_q); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && flush_done && !(wr && loc == OF_CTRL && req_wdata[1]) |=> !flush_req); // R5
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) && !we_stat |=> $stable(eaddr_q)); // R8
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    we_stat && req_wdata[4] == 1'b0 && req_wdata[2:0] == 3'b0 && !flt_valid |=> flags_q == 4'b0 && !irq); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] |-> !irq); // R10
endmodule

// File: tb/sim_mmu_ctx_regs.sv
module sim_mmu_ctx_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, flt_valid = 0, flush_done = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, flt_addr = '0, req_rdata;
  logic [3:0] flt_flags = '0;
  logic [2:0] flt_code = '0;
  logic [1:0] flt_level = '0;
  logic flush_req, xlat_en, irq;

  int checks = 0, fails = 0;

  logic [31:0] m_ctrl, m_tcfg, m_tbl, m_tbh, m_at0, m_at1, m_eaddr;
  logic [2:0]  m_bus, m_code;
  logic [1:0]  m_lvl;
  logic [3:0]  m_flags;
  logic        m_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_ctx_regs u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata), .flt_valid(flt_valid),
    .flt_flags(flt_flags), .flt_code(flt_code), .flt_level(flt_level), .flt_addr(flt_addr),
    .flush_done(flush_done), .flush_req(flush_req), .xlat_en(xlat_en), .irq(irq));

  function automatic logic [11:0] eff(input logic [11:0] a);
    return {1'b0, a[10:0]};
  endfunction

  function automatic bit is_mapped(input logic [11:0] a);
    logic [11:0] e = eff(a);
    return e[1:0] == 2'b00 && (e == 12'h00 || e == 12'h08 || e == 12'h0C || e == 12'h10 ||
      e == 12'h14 || e == 12'h20 || e == 12'h28 || e == 12'h2C || e == 12'h30);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (!is_mapped(a)) return 32'h0;
    case (eff(a))
      12'h00: return m_ctrl | {30'b0, m_flush, 1'b0};
      12'h08: return m_tcfg;
      12'h0C: return {29'b0, m_bus};
      12'h10: return m_tbl;
      12'h14: return m_tbh;
      12'h20: return {18'b0, m_lvl, 1'b0, m_code, 3'b0, m_flags[3], 1'b0, m_flags[2:0]};
      12'h28: return m_at0;
      12'h2C: return m_at1;
      default: return (m_flags != 0) ? m_eaddr : 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (!is_mapped(a)) return "R2";
    case (eff(a))
      12'h00: return "R4";
      12'h20: return "R7";
      12'h30: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_tcfg = 0; m_tbl = 0; m_tbh = 0; m_at0 = 0; m_at1 = 0; m_eaddr = 0;
    m_bus = 0; m_code = 0; m_lvl = 0; m_flags = 0; m_flush = 0;
  endtask

  task automatic model_apply(input bit w, input logic [11:0] a, input logic [31:0] d, input bit fv,
      input logic [3:0] ff, input logic [2:0] fc, input logic [1:0] fl, input logic [31:0] fa, input bit fd);
    logic [3:0] base = m_flags;
    bit wm = w && is_mapped(a);
    logic [11:0] e = eff(a);
    bit set_fl = wm && e == 12'h00 && d[1];
    if (wm && e == 12'h20) base = m_flags & {d[4], d[2:0]};
    if (fv && ff != 0 && base == 0) begin
      m_code = fc; m_lvl = fl; m_eaddr = fa;
    end else if (base == 0) begin
      m_code = 0; m_lvl = 0; m_eaddr = 0;
    end
    m_flags = base | (fv ? ff : 4'b0);
    m_flush = set_fl || (m_flush && !fd);
    if (wm) case (e)
      12'h00: m_ctrl = d & 32'h0003_003D;
      12'h08: m_tcfg = d;
      12'h0C: m_bus  = d[2:0];
      12'h10: m_tbl  = d;
      12'h14: m_tbh  = d;
      12'h28: m_at0  = d;
      12'h2C: m_at1  = d;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [11:0] a, input logic [31:0] d, input bit fv,
      input logic [3:0] ff, input logic [2:0] fc, input logic [1:0] fl, input logic [31:0] fa, input bit fd);
    @(negedge clk);
    req_valid = w; req_write = w; req_addr = a; req_wdata = d;
    flt_valid = fv; flt_flags = ff; flt_code = fc; flt_level = fl; flt_addr = fa; flush_done = fd;
    @(posedge clk);
    model_apply(w, a, d, fv, ff, fc, fl, fa, fd);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 0;
    flt_valid = 0; flt_flags = 0; flush_done = 0;
    #1;
    check(req, req_rdata, exp_read(a));
    check("R10", {31'b0, irq}, {31'b0, m_ctrl[2] && (m_flags != 0)});
    check("R4", {31'b0, flush_req}, {31'b0, m_flush});
    check("R3", {31'b0, xlat_en}, {31'b0, m_ctrl[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] offs [12];
    offs = '{12'h00, 12'h08, 12'h0C, 12'h10, 12'h14, 12'h20, 12'h28, 12'h2C, 12'h30,
             12'h04, 12'h1C, 12'h3C};
    void'($urandom(32'd5150));
    model_reset();
    #(CLK_PERIOD * 2 + 3);
    rst_n = 1;
    // R1: reset state across every offset
    for (int i = 0; i < 12; i++) rd_chk(offs[i], "R1");
    // R2: alias window and unmapped / misaligned offsets
    wr(12'h808, 32'hCAFE_F00D);
    rd_chk(12'h008, "R2");
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk(12'h804, "R2");
    rd_chk(12'h009, "R2");
    rd_chk(12'h040, "R2");
    // R3: control mask
    wr(12'h000, 32'hFFFF_FFFD);
    rd_chk(12'h000, "R3");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk(12'h80C, "R3");
    // R4: flush held, write 0 does not clear
    wr(12'h000, 32'h0000_0007);
    wr(12'h000, 32'h0000_0005);
    rd_chk(12'h000, "R4");
    // R5: ack same cycle as a new request keeps the bit
    step(1, 12'h000, 32'h0000_0007, 0, 0, 0, 0, 0, 1);
    rd_chk(12'h000, "R5");
    step(0, 12'h000, 0, 0, 0, 0, 0, 0, 1);
    rd_chk(12'h000, "R5");
    step(0, 12'h000, 0, 0, 0, 0, 0, 0, 1);
    rd_chk(12'h000, "R5");
    // R8: first fault latches, second only adds flags
    step(0, 12'h000, 0, 1, 4'b0001, 3'd4, 2'd2, 32'h1234_5000, 0);
    step(0, 12'h000, 0, 1, 4'b1000, 3'd5, 2'd1, 32'h9999_0000, 0);
    rd_chk(12'h030, "R8");
    rd_chk(12'h020, "R8");
    // R6: partial clear keeps the latch, full clear zeroes it
    wr(12'h020, 32'h0000_0010);
    rd_chk(12'h020, "R6");
    rd_chk(12'h830, "R6");
    wr(12'h020, 32'h0);
    rd_chk(12'h030, "R6");
    rd_chk(12'h020, "R6");
    // R9: clear and fault together, fault latches as first
    step(0, 12'h000, 0, 1, 4'b0010, 3'd1, 2'd3, 32'hAAAA_0000, 0);
    step(1, 12'h020, 32'h0, 1, 4'b0100, 3'd5, 2'd1, 32'hBBBB_0000, 0);
    rd_chk(12'h030, "R9");
    rd_chk(12'h020, "R9");
    // R8: empty fault ignored
    wr(12'h020, 32'h0);
    step(0, 12'h000, 0, 1, 4'b0000, 3'd7, 2'd3, 32'hDEAD_0000, 0);
    rd_chk(12'h020, "R8");
    // R7: error address read-only
    wr(12'h030, 32'h5555_5555);
    rd_chk(12'h030, "R7");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a = offs[$urandom_range(0, 11)] | ($urandom_range(0, 1) ? 12'h800 : 12'h0);
      bit w = $urandom_range(0, 2) != 0;
      logic [31:0] d = $urandom;
      if (a[10:0] == 11'h20 && $urandom_range(0, 1)) d = d & 32'hFFFF_FFE8;
      step(w, a, d, $urandom_range(0, 3) == 0, 4'($urandom), 3'($urandom), 2'($urandom), $urandom,
           $urandom_range(0, 3) == 0);
      a = offs[$urandom_range(0, 11)];
      rd_chk(a, tag_of(a));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule